// File: doc/BRIEF.md
# Sign-Restoring Register Read Multiplexer

This block sits on the read side of a register file in which neighbouring registers are paired and lend each other their unused upper bytes. A register holding a short integer keeps only its meaningful low bytes. Its upper bytes may be carrying a mirrored copy of its partner's data. On every read, the block rebuilds the true two's-complement value from the raw stored word and a small amount of side information. That side information is a length tag giving the index of the highest meaningful byte, a sign bit, and a flag marking words that were stored with their bytes reversed.

Each output byte lane is produced by a four-way selector. The choices are the stored byte in its own lane, the byte from the mirrored lane, all zeros, or all ones. The reversed byte order is undone before the sign fill is applied. A parameter chooses where the sign comes from: the stored sign input, or the top bit of the highest meaningful byte of the restored word. A second parameter places an optional register on the output.

Top module: `rf_signfill_rdmux`

## Requirements
- R1: Every byte lane whose index is less than or equal to `len_tag` carries the matching byte of the restored word. Lane 0 is therefore always meaningful.
- R2: With `len_tag` = 3 and `swapped` = 0, the output equals `raw_word` bit for bit.
- R3: Every lane whose index is greater than `len_tag` reads 0x00 when the sign is 0 and 0xFF when the sign is 1.
- R4: With STORED_SIGN = 1, the sign is the `sign_bit` input. Bits of `raw_word` have no influence on the fill value.
- R5: With STORED_SIGN = 0, the sign is bit 8*(`len_tag`+1)-1 of the restored word, and `sign_bit` has no effect.
- R6: When `swapped` = 1, restored byte k is raw byte 3-k (a full byte reversal). This reversal is applied before the length and sign steps.
- R7: With REG_OUT = 1, the output shows the result for the inputs present at a rising clock edge from that edge until the next one. With REG_OUT = 0, the output follows the inputs within the same cycle.
- R8: With REG_OUT = 1, the output is 0 while `rst_n` is low.
- R9: The content of raw lanes above the effective length (the mirrored partner data) never reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_word | input | 32 | Word exactly as held in the storage cells |
| len_tag | input | 2 | Index of the highest meaningful byte (0 to 3) |
| sign_bit | input | 1 | Sign recorded at write time (used when STORED_SIGN = 1) |
| swapped | input | 1 | 1 when the word was stored byte-reversed |
| rd_word | output | 32 | Restored two's-complement read value |

## Verification
The bench aims at four weak points.

- Upper lanes filled with a partner's data that contradicts the sign. A design that passes lanes through without regard to the tag would leak the partner's bytes.
- Reversed words whose sign byte sits in raw lane 3 while the tag is 0. A design that derives the sign before undoing the reversal would fill with the wrong polarity.
- Contradiction between the two sign sources. A stored sign that disagrees with the top data bit, and a toggled `sign_bit` in the derived variant, expose a design that reads the wrong sign source.
- Timing and the full-length case. One-cycle sampling of the registered variant catches an extra or missing pipeline stage. Tag 3 words catch an off-by-one in the lane comparison that would overwrite the top byte.

// File: rtl/rdmux_pkg.sv
package rdmux_pkg;

    typedef enum logic [1:0] {
        LANE_DIRECT  = 2'd0,
        LANE_SWAPPED = 2'd1,
        LANE_ZERO    = 2'd2,
        LANE_ONES    = 2'd3
    } lane_sel_e;

endpackage

// File: rtl/rdmux_sign.sv
module rdmux_sign #(
    parameter int NBYTES = 4,
    parameter int BYTE_W = 8,
    localparam int WORD_W = NBYTES * BYTE_W,
    localparam int TAG_W  = $clog2(NBYTES)
) (
    input  logic [WORD_W-1:0] raw_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic              swapped_i,
    output logic              sign_o
);

    logic [TAG_W-1:0] raw_lane;

    // The top meaningful byte sits in the mirrored raw lane when the word is reversed.
    always_comb begin
        raw_lane = swapped_i ? TAG_W'(NBYTES - 1) - tag_i : tag_i;
        sign_o   = 1'b0;
        for (int k = 0; k < NBYTES; k++) begin
            if (raw_lane == TAG_W'(k)) begin
                sign_o = raw_i[k*BYTE_W + BYTE_W - 1];
            end
        end
    end

endmodule

// File: rtl/rdmux_ctl.sv
module rdmux_ctl #(
    parameter int NBYTES = 4,
    localparam int TAG_W = $clog2(NBYTES)
) (
    input  logic [TAG_W-1:0]        tag_i,
    input  logic                    swapped_i,
    input  logic                    sign_i,
    output logic [NBYTES-1:0][1:0]  sel_o
);
    import rdmux_pkg::*;

    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        lane_sel_e sel_d;
        always_comb begin
            if (TAG_W'(k) <= tag_i) begin
                sel_d = swapped_i ? LANE_SWAPPED : LANE_DIRECT;
            end else begin
                sel_d = sign_i ? LANE_ONES : LANE_ZERO;
            end
        end
        assign sel_o[k] = sel_d;
    end

endmodule

// File: rtl/rdmux_bytesel.sv
module rdmux_bytesel #(
    parameter int NBYTES = 4,
    parameter int BYTE_W = 8,
    localparam int WORD_W = NBYTES * BYTE_W
) (
    input  logic [WORD_W-1:0]       raw_i,
    input  logic [NBYTES-1:0][1:0]  sel_i,
    output logic [WORD_W-1:0]       word_o
);
    import rdmux_pkg::*;

    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        localparam int MIR = NBYTES - 1 - k;
        always_comb begin
            case (lane_sel_e'(sel_i[k]))
                LANE_DIRECT:  word_o[k*BYTE_W +: BYTE_W] = raw_i[k*BYTE_W +: BYTE_W];
                LANE_SWAPPED: word_o[k*BYTE_W +: BYTE_W] = raw_i[MIR*BYTE_W +: BYTE_W];
                LANE_ZERO:    word_o[k*BYTE_W +: BYTE_W] = '0;
                default:      word_o[k*BYTE_W +: BYTE_W] = '1;
            endcase
        end
    end

endmodule

// File: rtl/rf_signfill_rdmux.sv
module rf_signfill_rdmux #(
    parameter int NBYTES      = 4,
    parameter int BYTE_W      = 8,
    parameter bit STORED_SIGN = 1'b1,
    parameter bit REG_OUT     = 1'b1,
    localparam int WORD_W = NBYTES * BYTE_W,
    localparam int TAG_W  = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] raw_word,
    input  logic [TAG_W-1:0]  len_tag,
    input  logic              sign_bit,
    input  logic              swapped,
    output logic [WORD_W-1:0] rd_word
);

    logic                   sign_w;
    logic [NBYTES-1:0][1:0] sel_w;
    logic [WORD_W-1:0]      fill_w;

    if (STORED_SIGN) begin : g_sign_stored
        assign sign_w = sign_bit;
    end else begin : g_sign_derived
        logic unused_stored_sign;
        assign unused_stored_sign = sign_bit;
        rdmux_sign #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_sign (
            .raw_i     (raw_word),
            .tag_i     (len_tag),
            .swapped_i (swapped),
            .sign_o    (sign_w)
        );
    end

    rdmux_ctl #(.NBYTES(NBYTES)) u_ctl (
        .tag_i     (len_tag),
        .swapped_i (swapped),
        .sign_i    (sign_w),
        .sel_o     (sel_w)
    );

    rdmux_bytesel #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_sel (
        .raw_i  (raw_word),
        .sel_i  (sel_w),
        .word_o (fill_w)
    );

    if (REG_OUT) begin : g_reg
        typedef struct packed {
            logic [WORD_W-1:0] word;
        } rd_state_t;

        rd_state_t st_d, st_q;

        always_comb begin
            st_d      = st_q;
            st_d.word = fill_w;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign rd_word = st_q.word;
    end else begin : g_comb
        assign rd_word = fill_w;
    end

    // R1: lane 0 always carries the restored low byte
    a_r1_low_lane: assert property (@(posedge clk) disable iff (!rst_n)
        fill_w[BYTE_W-1:0] == (swapped ? raw_word[WORD_W-1 -: BYTE_W] : raw_word[BYTE_W-1:0]));

    // R2: full-length, unreversed word is returned untouched
    a_r2_full_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (len_tag == '1 && !swapped) |-> fill_w == raw_word);

    // R3: with only lane 0 meaningful, all upper lanes are one uniform fill
    a_r3_uniform_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (len_tag == '0) |->
        ($countones(fill_w[WORD_W-1:BYTE_W]) == 0 ||
         $countones(fill_w[WORD_W-1:BYTE_W]) == WORD_W - BYTE_W));

    if (STORED_SIGN) begin : g_a_stored
        // R4: a short word's top bit follows the recorded sign
        a_r4_stored_sign: assert property (@(posedge clk) disable iff (!rst_n)
            (len_tag != '1) |-> fill_w[WORD_W-1] == sign_bit);
    end else begin : g_a_derived
        // R5: a one-byte word, unreversed, extends its own bit 7
        a_r5_derived_sign: assert property (@(posedge clk) disable iff (!rst_n)
            (len_tag == '0 && !swapped) |-> fill_w[WORD_W-1] == raw_word[BYTE_W-1]);
    end

endmodule

// File: tb/sim_rf_signfill_rdmux.sv
module sim_rf_signfill_rdmux;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] raw_word = '0;
    logic [1:0]  len_tag = '0;
    logic        sign_bit = 1'b0;
    logic        swapped = 1'b0;
    logic [31:0] rd0, rd1;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // u0: recorded sign, registered output. u1: derived sign, combinational.
    rf_signfill_rdmux #(.STORED_SIGN(1'b1), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .raw_word(raw_word), .len_tag(len_tag),
        .sign_bit(sign_bit), .swapped(swapped), .rd_word(rd0));

    rf_signfill_rdmux #(.STORED_SIGN(1'b0), .REG_OUT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .raw_word(raw_word), .len_tag(len_tag),
        .sign_bit(sign_bit), .swapped(swapped), .rd_word(rd1));

    function automatic logic [31:0] model(input logic [31:0] raw, input logic [1:0] tag,
                                          input logic sb, input logic sw, input bit stored);
        logic [31:0] r;
        logic s;
        int t;
        t = int'(tag);
        r = sw ? {raw[7:0], raw[15:8], raw[23:16], raw[31:24]} : raw;
        s = stored ? sb : r[8*(t+1)-1];
        for (int k = 0; k < 4; k++) begin
            if (k > t) r[8*k +: 8] = s ? 8'hFF : 8'h00;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Drive at the falling edge; check u1 just after, u0 just after the next rising edge.
    task automatic step(input string req, input logic [31:0] raw, input logic [1:0] tag,
                        input logic sb, input logic sw);
        logic [31:0] e0;
        @(negedge clk);
        raw_word = raw; len_tag = tag; sign_bit = sb; swapped = sw;
        #1;
        check({req, " derived/comb (R5 R7)"}, rd1, model(raw, tag, sb, sw, 1'b0));
        e0 = model(raw, tag, sb, sw, 1'b1);
        @(posedge clk);
        #1;
        check({req, " stored/registered (R4 R7)"}, rd0, e0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        raw_word = 32'hDEAD_BEEF; len_tag = 2'd3;
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset value", rd0, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: full length passes unchanged
        step("R2 full length", 32'h8123_4567, 2'd3, 1'b0, 1'b0);
        check("R2 explicit", rd0, 32'h8123_4567);
        // R3: negative one-byte value
        step("R3 ones fill", 32'h1234_5680, 2'd0, 1'b1, 1'b0);
        check("R3 explicit", rd0, 32'hFFFF_FF80);
        // R9: partner data above length is hidden
        step("R9 partner bytes", 32'hAAAA_AA05, 2'd0, 1'b0, 1'b0);
        check("R9 explicit", rd1, 32'h0000_0005);
        // R6: full reversal restored
        step("R6 reversal full", 32'h1122_3344, 2'd3, 1'b0, 1'b1);
        check("R6 explicit", rd0, 32'h4433_2211);
        // R6: sign derived after reversal (raw lane 3 holds the meaningful byte)
        step("R6 reversal short", 32'h7F00_00FF, 2'd0, 1'b0, 1'b1);
        check("R6 derived sign after undo", rd1, 32'h0000_007F);
        // R4: recorded sign wins over data bits
        step("R4 stored sign", 32'h0000_0012, 2'd1, 1'b1, 1'b0);
        check("R4 explicit", rd0, 32'hFFFF_0012);
        check("R5 sign_bit ignored", rd1, 32'h0000_0012);
        // R5: derived sign from bit 15 and bit 23
        step("R5 two bytes", 32'h0000_8001, 2'd1, 1'b0, 1'b0);
        check("R5 explicit bit15", rd1, 32'hFFFF_8001);
        step("R5 three bytes", 32'h5A80_0000, 2'd2, 1'b0, 1'b0);
        check("R5 explicit bit23", rd1, 32'hFF80_0000);
        // R1: meaningful lanes pass
        step("R1 three bytes", 32'h5A12_3456, 2'd2, 1'b0, 1'b0);
        check("R1 explicit", rd0, 32'h0012_3456);
        // R7: registered output holds until the next edge
        @(negedge clk);
        raw_word = 32'h0000_0001; len_tag = 2'd0; sign_bit = 1'b1; swapped = 1'b0;
        #1;
        check("R7 registered holds previous", rd0, 32'h0012_3456);
        check("R7 comb follows now", rd1, 32'h0000_0001);

        for (int i = 0; i < 400; i++) begin
            step("R1 R3 random", $urandom, 2'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule